// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Overcurrent Limiting

This block is the control logic for one phase of a motor inverter. It takes a PWM command, an active-low phase reset and two overcurrent comparator flags, one for the high-side switch and one for the low-side switch. From these it drives the two gate enables of the half bridge. Between one switch turning off and the other turning on, it holds both switches off for a fixed number of clock cycles.

A mode input selects how the block reacts to overcurrent. In cycle-limiting mode, a trip overrides the PWM command only until the PWM input next changes level. If the PWM input stays static for too long after a trip, both switches are parked off until it toggles. In latching mode, any trip turns the bridge off and raises a shutdown flag. The bridge stays off until the phase reset produces a rising edge.

A device supervisor can turn the bridge off at once with a force-off input, for example on undervoltage or overtemperature. The PWM input and the phase reset are asynchronous and pass through two-flop synchronizers. The comparator flags, the mode input and the force-off input are taken to be synchronous to the block clock.

Top module: `hb_gate_ctrl`

## Requirements
- R1: With no trip and the phase reset high, a level change on `pwm_in` written just before clock edge E1 turns off the conducting switch at edge E3. A high PWM level selects the high-side gate and a low level selects the low-side gate.
- R2: `gate_hi` and `gate_lo` are never high together. When the gates hand over from one side to the other, both stay low for at least DEAD_CYC clock cycles. In a plain PWM handover the gap is exactly DEAD_CYC cycles.
- R3: In cycle-limiting mode (`latch_mode`=0), a high-side flag sampled at an edge turns `gate_hi` off at that edge. The low-side switch then turns on after the dead time and stays on until `pwm_in` changes level.
- R4: In cycle-limiting mode, a low-side flag sampled at an edge turns both gates off at that edge. They stay off until `pwm_in` changes level.
- R5: After a cycle-limiting trip, if STALL_CYC cycles pass with no PWM level change and no new flag, both gates go low. They stay low until the synchronized PWM level changes.
- R6: In latching mode (`latch_mode`=1), either flag turns both gates off at the edge where it is sampled and sets `shutdown`=1. PWM activity does not change this state. It clears only at the edge after the synchronized phase reset rises.
- R7: While the synchronized phase reset is low, both gates are low. A rising edge of the phase reset also clears any cycle-limiting override, so normal PWM following resumes.
- R8: While `force_off`=1, both gate outputs are low in the same cycle. After release, the gates restart under the dead-time rule.
- R9: During and right after the system reset `rst_n`, both gates and `shutdown` are low.
- R10: `shutdown` is high only while a latching-mode trip is held. A cycle-limiting trip never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pwm_in | input | 1 | Asynchronous PWM command, 1 selects the high side |
| phase_rst_n | input | 1 | Asynchronous active-low reset for this phase |
| oc_hi | input | 1 | High-side overcurrent flag, synchronous |
| oc_lo | input | 1 | Low-side overcurrent flag, synchronous |
| latch_mode | input | 1 | 0 selects cycle limiting, 1 selects latching shutdown |
| force_off | input | 1 | Supervisor request to turn both switches off |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| shutdown | output | 1 | Latched overcurrent shutdown flag |

## Verification
A protection state that is stuck or wrong shows up at the gates within one clock edge. A gate stays high after a flag, or a latched phase comes back on when the PWM toggles. The synchronizer depth and the dead-time counter can only be seen as timing at the ports: a handover gap of the wrong length, or a turn-off that is one edge early or late. A stall counter that miscounts shows only after a static PWM level has been held for STALL_CYC cycles, as the parked-off state arriving early or late. For this reason the bench follows the outputs every cycle against a cycle model built from the requirements, and holds the PWM level static on purpose.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_HI_TRIP  = 3'd1,
    ST_LO_TRIP  = 3'd2,
    ST_HOLD_OFF = 3'd3,
    ST_LATCHED  = 3'd4
  } prot_state_t;

  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int WIDTH   = 2,
  parameter int STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/hb_oc_fsm.sv
module hb_oc_fsm
  import hb_pkg::*;
#(
  parameter int STALL_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwm_s,
  input  logic        prst_s,
  input  logic        oc_hi,
  input  logic        oc_lo,
  input  logic        latch_mode,
  input  logic        force_off,
  output gate_pair_t  req,
  output prot_state_t st_q,
  output logic        prst_rise
);

  localparam int SW = (STALL_CYC > 2) ? $clog2(STALL_CYC) : 1;
  localparam logic [SW-1:0] STALL_LAST = SW'(STALL_CYC - 1);

  prot_state_t   st_d;
  logic          pwm_d, prst_d;
  logic          pwm_tog, any_oc, in_trip;
  logic [SW-1:0] stall_q, stall_d;

  assign pwm_tog   = pwm_s ^ pwm_d;
  assign prst_rise = prst_s & ~prst_d;
  assign any_oc    = oc_hi | oc_lo;
  assign in_trip   = (st_q == ST_HI_TRIP) || (st_q == ST_LO_TRIP);

  // Next protection state: phase reset edge first, then hold, then flags.
  always_comb begin
    st_d = st_q;
    if (prst_rise) begin
      st_d = ST_RUN;
    end else if (!prst_s || st_q == ST_LATCHED) begin
      st_d = st_q;
    end else if (latch_mode && any_oc) begin
      st_d = ST_LATCHED;
    end else if (oc_lo) begin
      st_d = ST_LO_TRIP;
    end else if (oc_hi) begin
      st_d = ST_HI_TRIP;
    end else begin
      case (st_q)
        ST_HI_TRIP, ST_LO_TRIP: begin
          if (pwm_tog)                   st_d = ST_RUN;
          else if (stall_q == STALL_LAST) st_d = ST_HOLD_OFF;
        end
        ST_HOLD_OFF: if (pwm_tog) st_d = ST_RUN;
        default:     st_d = ST_RUN;
      endcase
    end
  end

  // Quiet cycles spent in a trip state with a static PWM level.
  always_comb begin
    if (prst_s && !prst_rise && !any_oc && !pwm_tog && in_trip && st_d == st_q)
      stall_d = stall_q + SW'(1);
    else
      stall_d = '0;
  end

  // Gate request follows the next state so a flag acts at the edge it is sampled.
  always_comb begin
    req = '0;
    if (!force_off && prst_s) begin
      case (st_d)
        ST_RUN: begin
          req.hi = pwm_s;
          req.lo = ~pwm_s;
        end
        ST_HI_TRIP: req.lo = 1'b1;
        default:    req = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      stall_q <= '0;
      pwm_d   <= 1'b0;
      prst_d  <= 1'b0;
    end else begin
      st_q    <= st_d;
      stall_q <= stall_d;
      pwm_d   <= pwm_s;
      prst_d  <= prst_s;
    end
  end

endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  gate_pair_t req,
  output gate_pair_t gq
);

  localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC + 1) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(DEAD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  gate_pair_t    gd;
  logic          quiet, turn_off;

  assign quiet = (cnt_q == '0);

  // Turn-off is immediate; turn-on waits for the other side and the counter.
  always_comb begin
    gd.hi    = req.hi & (gq.hi | (~gq.lo & quiet));
    gd.lo    = req.lo & (gq.lo | (~gq.hi & quiet));
    turn_off = (gq.hi & ~gd.hi) | (gq.lo & ~gd.lo);
    if (turn_off)    cnt_d = LOAD_VAL;
    else if (!quiet) cnt_d = cnt_q - CW'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gq    <= '0;
      cnt_q <= '0;
    end else begin
      gq    <= gd;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_pkg::*;
#(
  parameter int DEAD_CYC  = 3,
  parameter int STALL_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic phase_rst_n,
  input  logic oc_hi,
  input  logic oc_lo,
  input  logic latch_mode,
  input  logic force_off,
  output logic gate_hi,
  output logic gate_lo,
  output logic shutdown
);

  logic [1:0]  sync_out;
  logic        pwm_s, prst_s, prst_rise;
  gate_pair_t  req, gq;
  prot_state_t st_q;

  hb_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b00)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({pwm_in, phase_rst_n}),
    .dout (sync_out)
  );

  assign pwm_s  = sync_out[1];
  assign prst_s = sync_out[0];

  hb_oc_fsm #(.STALL_CYC(STALL_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_s     (pwm_s),
    .prst_s    (prst_s),
    .oc_hi     (oc_hi),
    .oc_lo     (oc_lo),
    .latch_mode(latch_mode),
    .force_off (force_off),
    .req       (req),
    .st_q      (st_q),
    .prst_rise (prst_rise)
  );

  hb_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .gq   (gq)
  );

  assign gate_hi  = gq.hi & ~force_off;
  assign gate_lo  = gq.lo & ~force_off;
  assign shutdown = (st_q == ST_LATCHED);

endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic oc_hi,
  input logic oc_lo,
  input logic force_off,
  input logic gate_hi,
  input logic gate_lo,
  input logic shutdown,
  input logic prst_s,
  input logic prst_rise
);

  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  assert_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> !$past(gate_lo));

  assert_hi_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_hi && prst_s && !prst_rise) |=> !gate_hi);

  assert_lo_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_lo && prst_s && !prst_rise) |=> (!gate_hi && !gate_lo));

  assert_latch_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!gate_hi && !gate_lo));

  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !prst_rise) |=> shutdown);

  assert_phase_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !prst_s |=> (!gate_hi && !gate_lo));

  assert_phase_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prst_rise |=> !shutdown);

  assert_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (!gate_hi && !gate_lo));

endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .oc_hi    (oc_hi),
  .oc_lo    (oc_lo),
  .force_off(force_off),
  .gate_hi  (gate_hi),
  .gate_lo  (gate_lo),
  .shutdown (shutdown),
  .prst_s   (prst_s),
  .prst_rise(prst_rise)
);

// File: tb/test_hb_gate_ctrl.sv
module test_hb_gate_ctrl;

  localparam int CLK_P  = 10;
  localparam int DEAD   = 3;
  localparam int STALL  = 16;
  localparam int S_RUN = 0, S_HI = 1, S_LO = 2, S_HOLD = 3, S_LAT = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic pwm_in = 0, phase_rst_n = 0, oc_hi = 0, oc_lo = 0, latch_mode = 0, force_off = 0;
  logic gate_hi, gate_lo, shutdown;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit m_p1, m_ps, m_pd, m_r1, m_rs, m_rd, m_hq, m_lq;
  int m_st, m_stall, m_cnt;

  // handover tracking
  bit p_gh, p_gl;
  int last_side, gap;

  always #(CLK_P/2) clk = ~clk;

  hb_gate_ctrl #(.DEAD_CYC(DEAD), .STALL_CYC(STALL)) i_hb_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .phase_rst_n(phase_rst_n),
    .oc_hi(oc_hi), .oc_lo(oc_lo), .latch_mode(latch_mode), .force_off(force_off),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .shutdown(shutdown)
  );

  function automatic bit is_trip(int s);
    return (s == S_HI) || (s == S_LO);
  endfunction

  function automatic string tag_for();
    if (force_off) return "R8";
    if (!m_rs)     return "R7";
    case (m_st)
      S_HI:    return "R3";
      S_LO:    return "R4";
      S_HOLD:  return "R5";
      S_LAT:   return "R6";
      default: return "R1";
    endcase
  endfunction

  // Cycle model written from the requirements.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 = 0; m_ps = 0; m_pd = 0; m_r1 = 0; m_rs = 0; m_rd = 0;
      m_hq = 0; m_lq = 0; m_st = S_RUN; m_stall = 0; m_cnt = 0;
    end else begin
      bit tog, rise, anyoc, rh, rl, hn, ln;
      int nst;
      tog = m_ps ^ m_pd;
      rise = m_rs & !m_rd;
      anyoc = oc_hi | oc_lo;
      nst = m_st;
      if (rise) nst = S_RUN;
      else if (!m_rs || m_st == S_LAT) nst = m_st;
      else if (latch_mode && anyoc) nst = S_LAT;
      else if (oc_lo) nst = S_LO;
      else if (oc_hi) nst = S_HI;
      else if (is_trip(m_st)) begin
        if (tog) nst = S_RUN;
        else if (m_stall == STALL - 1) nst = S_HOLD;
      end else if (m_st == S_HOLD) begin
        if (tog) nst = S_RUN;
      end else nst = S_RUN;
      if (m_rs && !rise && !anyoc && !tog && is_trip(m_st) && nst == m_st) m_stall = m_stall + 1;
      else m_stall = 0;
      rh = 0; rl = 0;
      if (!force_off && m_rs) begin
        if (nst == S_RUN) begin rh = m_ps; rl = !m_ps; end
        else if (nst == S_HI) rl = 1;
      end
      hn = rh && (m_hq || (!m_lq && m_cnt == 0));
      ln = rl && (m_lq || (!m_hq && m_cnt == 0));
      if ((m_hq && !hn) || (m_lq && !ln)) m_cnt = DEAD - 1;
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
      m_hq = hn; m_lq = ln; m_st = nst;
      m_pd = m_ps; m_ps = m_p1; m_p1 = pwm_in;
      m_rd = m_rs; m_rs = m_r1; m_r1 = phase_rst_n;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic model_check();
    string t;
    bit eh, el, gh, gl;
    t = tag_for();
    eh = m_hq && !force_off;
    el = m_lq && !force_off;
    gh = gate_hi; gl = gate_lo;
    chk({gh, gl} == {eh, el}, t, "gates{hi,lo}", {gh, gl}, {eh, el});
    chk(shutdown == (m_st == S_LAT), "R10", "shutdown", shutdown, m_st == S_LAT);
    chk(!(gh && gl), "R2", "both gates high", 1, 0);
    if (gh && !p_gh && last_side == 2) chk(gap >= DEAD, "R2", "gap lo->hi", gap, DEAD);
    if (gl && !p_gl && last_side == 1) chk(gap >= DEAD, "R2", "gap hi->lo", gap, DEAD);
    if (gh) last_side = 1;
    if (gl) last_side = 2;
    gap = (gh || gl) ? 0 : gap + 1;
    p_gh = gh; p_gl = gl;
  endtask

  // one clock: sample a quarter period after the edge, return at the falling edge
  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
    model_check();
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    finish_run();
  end

  initial begin
    int per, duty, pcnt, hold_left, oc_left, f_left, r_left;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk(!gate_hi && !gate_lo, "R9", "gates in reset", {gate_hi, gate_lo}, 0);
    chk(!shutdown, "R9", "shutdown in reset", shutdown, 0);
    rst_n = 1; phase_rst_n = 1;
    @(negedge clk);
    #1;
    chk(!gate_hi && !gate_lo, "R9", "gates after reset", {gate_hi, gate_lo}, 0);

    // R1 / R2: latency and handover gap
    ticks(10);
    chk(gate_lo, "R1", "low side follows low PWM", gate_lo, 1);
    pwm_in = 1;
    ticks(2);
    chk(gate_lo, "R1", "low side still on after two edges", gate_lo, 1);
    tick();
    chk(!gate_lo && !gate_hi, "R1", "off at third edge", {gate_hi, gate_lo}, 0);
    ticks(DEAD - 1);
    chk(!gate_hi, "R2", "high side waits dead time", gate_hi, 0);
    tick();
    chk(gate_hi, "R2", "high side on after dead time", gate_hi, 1);

    // R3 then R5: high-side trip with static PWM
    oc_hi = 1;
    tick();
    chk(!gate_hi, "R3", "high side off at trip edge", gate_hi, 0);
    oc_hi = 0;
    ticks(DEAD + 1);
    chk(gate_lo, "R3", "low side takes over", gate_lo, 1);
    ticks(STALL + 2);
    chk(!gate_hi && !gate_lo, "R5", "parked off on static PWM", {gate_hi, gate_lo}, 0);
    pwm_in = 0;
    ticks(3 + DEAD);
    chk(gate_lo, "R5", "resume after toggle", gate_lo, 1);

    // R4: low-side trip
    oc_lo = 1;
    tick();
    chk(!gate_lo && !gate_hi, "R4", "both off at low trip", {gate_hi, gate_lo}, 0);
    oc_lo = 0;
    ticks(4);
    chk(!gate_lo, "R4", "stays off until toggle", gate_lo, 0);
    pwm_in = 1;
    ticks(8);

    // R6 / R7: latching mode and clear by phase reset edge
    latch_mode = 1;
    oc_hi = 1;
    tick();
    oc_hi = 0;
    chk(shutdown, "R6", "shutdown set", shutdown, 1);
    pwm_in = 0; ticks(5); pwm_in = 1; ticks(5);
    chk(shutdown && !gate_hi && !gate_lo, "R6", "latched despite PWM", {shutdown, gate_hi, gate_lo}, 4);
    phase_rst_n = 0; ticks(4);
    phase_rst_n = 1; ticks(2);
    chk(shutdown, "R6", "still latched before reset edge", shutdown, 1);
    tick();
    chk(!shutdown, "R7", "cleared by reset edge", shutdown, 0);
    latch_mode = 0;
    ticks(6);

    // R8: force off acts in the same cycle
    force_off = 1;
    #1;
    chk(!gate_hi && !gate_lo, "R8", "force off same cycle", {gate_hi, gate_lo}, 0);
    ticks(3);
    force_off = 0;
    ticks(6);

    // constrained random run
    per = 16; duty = 8; pcnt = 0; hold_left = 0; oc_left = 0; f_left = 0; r_left = 0;
    for (int n = 0; n < 6000; n++) begin
      tick();
      pcnt++;
      if (pcnt >= per) begin
        pcnt = 0;
        per = 8 + int'($urandom % 32);
        duty = 1 + int'($urandom % (per - 1));
      end
      if (hold_left > 0) hold_left--;
      else begin
        pwm_in = (pcnt < duty);
        if ($urandom % 300 == 0) hold_left = 20 + int'($urandom % 20);
      end
      if (oc_left > 0) oc_left--;
      else begin
        oc_hi = 0; oc_lo = 0;
        if ($urandom % 60 == 0) begin
          if (pwm_in) oc_hi = 1; else oc_lo = 1;
          if ($urandom % 8 == 0) begin oc_hi = 1; oc_lo = 1; end
          oc_left = int'($urandom % 3);
        end
      end
      if (f_left > 0) f_left--;
      else begin
        force_off = 0;
        if ($urandom % 250 == 0) begin force_off = 1; f_left = int'($urandom % 5); end
      end
      if (r_left > 0) begin
        r_left--;
        if (r_left == 0) phase_rst_n = 1;
      end else if ($urandom % 350 == 0) begin
        phase_rst_n = 0;
        r_left = 2 + int'($urandom % 5);
        if ($urandom % 2 == 0) latch_mode = ~latch_mode;
      end
    end
    finish_run();
  end

endmodule